// File: doc/BRIEF.md
# Arbitrated Dual-Port RAM with Mailbox Flags

This block is a synchronous two-port word memory with two identical sides, left and right. Each side has its own enable, write select, output enable, two byte-lane enables, address and data buses. Either side may read or write any word in any cycle, and the two sides may address the same word in the same cycle. Read data is registered. It is returned one clock after the request, with the old contents of the word.

When both sides touch the same word in the same cycle, a busy flag tells the losing side that its access collided. A strap input selects how busy is produced. In master mode the block produces busy itself and the left side always wins. In slave mode each side's busy comes from an input, so an external master device can arbitrate for a wider word built from several of these blocks. A side whose busy is high has its write dropped.

The two highest word addresses also serve as a mailbox. A write to one of them raises an interrupt flag on the opposite side. A read by the receiving side clears that flag. The default size is 4096 words of 16 bits, and both values are set by parameters.

Top module: `twin_port_ram`

## Requirements
- R1: Each side performs an independent read or write on every cycle its enable is high. Read data appears on that side's read bus one clock after the request and carries the contents before any write made in the same cycle. If both sides write the same byte of the same word without being blocked, the left data is kept.
- R2: While a side's enable is low, that side performs no access. One clock later its read bus is all zeros.
- R3: The low byte enable gates data bits [7:0] and the high byte enable gates bits [15:8] of a write. A disabled lane keeps its stored value.
- R4: A read lane is zero one clock later if the output enable was low or that lane's enable was low.
- R5: In master mode (strap high), the right busy output is high in the same cycle in which both sides are enabled on equal addresses. Otherwise it is low. The left busy output is always low in master mode.
- R6: In a master-mode collision, the right side's write is not performed and the left side's write is.
- R7: In slave mode (strap low), each busy output equals that side's busy input. A side with busy high has its write suppressed, but its read still proceeds.
- R8: A performed left write with at least one lane enabled to the top address (all ones) sets the right interrupt flag on the next clock. A right read of the top address clears it.
- R9: A performed right write with at least one lane enabled to the top address minus one sets the left interrupt flag on the next clock. A left read of that address clears it.
- R10: When a set and a clear of the same flag occur in the same cycle, the set wins. Synchronous active-low reset clears both flags and both read buses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| is_master | input | 1 | 1: busy generated internally; 0: busy taken from inputs |
| l_en | input | 1 | Left side enable |
| l_wr | input | 1 | Left side write select (1 write, 0 read) |
| l_oe | input | 1 | Left side output enable |
| l_hi_en | input | 1 | Left upper byte enable |
| l_lo_en | input | 1 | Left lower byte enable |
| l_addr | input | ADDR_W | Left word address |
| l_wdata | input | DATA_W | Left write data |
| l_rdata | output | DATA_W | Left read data, one clock after request |
| l_busy_in | input | 1 | Left busy from outside (slave mode) |
| l_busy | output | 1 | Left busy flag |
| l_int | output | 1 | Left mailbox interrupt flag |
| r_en | input | 1 | Right side enable |
| r_wr | input | 1 | Right side write select |
| r_oe | input | 1 | Right side output enable |
| r_hi_en | input | 1 | Right upper byte enable |
| r_lo_en | input | 1 | Right lower byte enable |
| r_addr | input | ADDR_W | Right word address |
| r_wdata | input | DATA_W | Right write data |
| r_rdata | output | DATA_W | Right read data, one clock after request |
| r_busy_in | input | 1 | Right busy from outside (slave mode) |
| r_busy | output | 1 | Right busy flag |
| r_int | output | 1 | Right mailbox interrupt flag |

## Verification
Random traffic is confined to a handful of words that include both mailbox words, so same-address collisions, write-with-read on one word and mailbox hits happen often in both strap modes. A design that let the right side win, or that wrote both colliding words, would return the wrong word on the following read. A design that returned new data on a same-cycle write would fail the read-first rule. Directed cases cover single-lane writes and reads with output enable low. They also cover a blocked write in slave mode whose read still has to return data, a disabled side that must leave memory untouched, and a flag set and clear in the same cycle, where a design giving priority to the clear would drop the message.

// File: rtl/twin_port_pkg.sv
// Package: shared constants and types for the twin-port RAM.
// Assumes data words are made of exactly two byte lanes.
package twin_port_pkg;
    localparam int LANES = 2;

    // Decoded per-side operation after arbitration
    typedef struct packed {
        logic rd;     // read requested this cycle
        logic wr_go;  // write actually performed this cycle
    } side_op_t;
endpackage

// File: rtl/tpr_collide.sv
// Module: busy-flag generation.
// Master mode: left wins a same-address collision and right gets busy.
// Slave mode: busy flags come straight from the external inputs.
// Assumes the two sides are indexed 0 = left, 1 = right.
module tpr_collide #(
    parameter int ADDR_W = 12
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   is_master,
    input  logic [1:0]             en,
    input  logic [1:0][ADDR_W-1:0] addr,
    input  logic [1:0]             busy_in,
    output logic [1:0]             busy
);
    logic clash;

    // Same-word detection between the two enabled sides
    always_comb clash = en[0] && en[1] && (addr[0] == addr[1]);

    // Select busy source by strap; left never loses locally
    always_comb begin
        if (is_master) begin
            busy[0] = 1'b0;
            busy[1] = clash;
        end else begin
            busy[0] = busy_in[0];
            busy[1] = busy_in[1];
        end
    end

    // R5
    master_left_never_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_master |-> !busy[0]);
    // R5
    master_clash_flags_right_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_master && en[0] && en[1] && addr[0] == addr[1]) |-> busy[1]);
    // R7
    slave_busy_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !is_master |-> (busy == busy_in));
endmodule

// File: rtl/tpr_store.sv
// Module: word storage with byte-lane writes and registered, read-first outputs.
// Writes are applied right side first and left side last, so the left data
// is kept on a same-word, same-lane double write. Read lanes that are not
// selected return zero. Storage contents are not reset.
module tpr_store
    import twin_port_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  side_op_t [1:0]         op,
    input  logic [1:0]             oe,
    input  logic [1:0][LANES-1:0]  be,
    input  logic [1:0][ADDR_W-1:0] addr,
    input  logic [1:0][DATA_W-1:0] wdata,
    output logic [1:0][DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int LW    = DATA_W / LANES;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [1:0][DATA_W-1:0] rq;

    // Byte-lane writes; loop order gives the left side the last word
    always_ff @(posedge clk) begin
        for (int p = 1; p >= 0; p--) begin
            for (int k = 0; k < LANES; k++) begin
                if (op[p].wr_go && be[p][k])
                    mem[addr[p]][k*LW +: LW] <= wdata[p][k*LW +: LW];
            end
        end
    end

    // Registered read lanes, zeroed when not selected
    always_ff @(posedge clk) begin
        for (int p = 0; p < 2; p++) begin
            for (int k = 0; k < LANES; k++) begin
                if (!rst_n)
                    rq[p][k*LW +: LW] <= '0;
                else if (op[p].rd && oe[p] && be[p][k])
                    rq[p][k*LW +: LW] <= mem[addr[p]][k*LW +: LW];
                else
                    rq[p][k*LW +: LW] <= '0;
            end
        end
    end

    assign rdata = rq;

    generate
        for (genvar g = 0; g < 2; g++) begin : g_side_chk
            // R2
            idle_side_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !op[g].rd && !op[g].wr_go |=> rdata[g] == '0);
            // R4
            oe_low_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !oe[g] |=> rdata[g] == '0);
            // R4
            no_lanes_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
                be[g] == '0 |=> rdata[g] == '0);
        end
    endgenerate
endmodule

// File: rtl/tpr_mailbox.sv
// Module: port-to-port interrupt flags.
// The top word signals left-to-right and the word below it signals
// right-to-left. A performed write sets the flag and a read by the receiving
// side clears it. A set beats a clear in the same cycle.
module tpr_mailbox
    import twin_port_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  side_op_t [1:0]         op,
    input  logic [1:0]             any_lane,
    input  logic [1:0][ADDR_W-1:0] addr,
    output logic                   int_l,
    output logic                   int_r
);
    localparam logic [ADDR_W-1:0] BOX_TO_R = '1;
    localparam logic [ADDR_W-1:0] BOX_TO_L = BOX_TO_R - 1'b1;

    logic set_r, clr_r, set_l, clr_l;

    // Decode the four mailbox events
    always_comb begin
        set_r = op[0].wr_go && any_lane[0] && (addr[0] == BOX_TO_R);
        clr_r = op[1].rd && (addr[1] == BOX_TO_R);
        set_l = op[1].wr_go && any_lane[1] && (addr[1] == BOX_TO_L);
        clr_l = op[0].rd && (addr[0] == BOX_TO_L);
    end

    // Flag registers with set priority
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            int_r <= 1'b0;
            int_l <= 1'b0;
        end else begin
            if (set_r)      int_r <= 1'b1;
            else if (clr_r) int_r <= 1'b0;
            if (set_l)      int_l <= 1'b1;
            else if (clr_l) int_l <= 1'b0;
        end
    end

    // R8
    right_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_r |=> int_r);
    // R8
    right_flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_r && !set_r |=> !int_r);
    // R9
    left_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_l |=> int_l);
    // R9
    left_flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_l && !set_l |=> !int_l);
    // R10
    flags_reset_chk: assert property (@(posedge clk)
        !rst_n |=> !int_l && !int_r);
    // R8
    right_flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !set_r && !clr_r |=> $stable(int_r));
endmodule

// File: rtl/twin_port_ram.sv
// Module: top of the arbitrated two-port RAM with mailbox flags.
// Packs the left and right pins into per-side arrays (0 = left, 1 = right),
// decodes reads and performed writes after busy, and joins the storage,
// busy and mailbox pieces.
module twin_port_ram
    import twin_port_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              is_master,
    input  logic              l_en,
    input  logic              l_wr,
    input  logic              l_oe,
    input  logic              l_hi_en,
    input  logic              l_lo_en,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    output logic [DATA_W-1:0] l_rdata,
    input  logic              l_busy_in,
    output logic              l_busy,
    output logic              l_int,
    input  logic              r_en,
    input  logic              r_wr,
    input  logic              r_oe,
    input  logic              r_hi_en,
    input  logic              r_lo_en,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] r_wdata,
    output logic [DATA_W-1:0] r_rdata,
    input  logic              r_busy_in,
    output logic              r_busy,
    output logic              r_int
);
    logic [1:0]             en, wr, oe, busy_in, busy, any_lane;
    logic [1:0][LANES-1:0]  be;
    logic [1:0][ADDR_W-1:0] addr;
    logic [1:0][DATA_W-1:0] wdata, rdata;
    side_op_t [1:0]         op;

    // Gather pins into side-indexed arrays
    always_comb begin
        en      = {r_en, l_en};
        wr      = {r_wr, l_wr};
        oe      = {r_oe, l_oe};
        busy_in = {r_busy_in, l_busy_in};
        be[0]   = {l_hi_en, l_lo_en};
        be[1]   = {r_hi_en, r_lo_en};
        addr[0] = l_addr;
        addr[1] = r_addr;
        wdata[0] = l_wdata;
        wdata[1] = r_wdata;
    end

    // Decode each side's read and surviving write
    always_comb begin
        for (int p = 0; p < 2; p++) begin
            any_lane[p]  = |be[p];
            op[p].rd     = en[p] && !wr[p];
            op[p].wr_go  = en[p] && wr[p] && !busy[p];
        end
    end

    tpr_collide #(.ADDR_W(ADDR_W)) u_collide (
        .clk       (clk),
        .rst_n     (rst_n),
        .is_master (is_master),
        .en        (en),
        .addr      (addr),
        .busy_in   (busy_in),
        .busy      (busy)
    );

    tpr_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .op    (op),
        .oe    (oe),
        .be    (be),
        .addr  (addr),
        .wdata (wdata),
        .rdata (rdata)
    );

    tpr_mailbox #(.ADDR_W(ADDR_W)) u_mailbox (
        .clk      (clk),
        .rst_n    (rst_n),
        .op       (op),
        .any_lane (any_lane),
        .addr     (addr),
        .int_l    (l_int),
        .int_r    (r_int)
    );

    assign l_rdata = rdata[0];
    assign r_rdata = rdata[1];
    assign l_busy  = busy[0];
    assign r_busy  = busy[1];

    // R6
    busy_blocks_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_busy || l_busy) |-> !(r_busy && op[1].wr_go) && !(l_busy && op[0].wr_go));
    // R2
    disabled_side_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !l_en |-> !op[0].rd && !op[0].wr_go);
endmodule

// File: tb/twin_port_ram_tb.sv
module twin_port_ram_tb;
    localparam int AW  = 12;
    localparam int DW  = 16;
    localparam int TOP = (1 << AW) - 1;

    logic clk = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    logic rst_n, is_master;
    logic l_en, l_wr, l_oe, l_hi_en, l_lo_en, l_busy_in, l_busy, l_int;
    logic r_en, r_wr, r_oe, r_hi_en, r_lo_en, r_busy_in, r_busy, r_int;
    logic [AW-1:0] l_addr, r_addr;
    logic [DW-1:0] l_wdata, r_wdata, l_rdata, r_rdata;

    twin_port_ram #(.ADDR_W(AW), .DATA_W(DW)) u_dut (.*);

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [DW-1:0] mdl [0:TOP];
    logic exp_li = 1'b0, exp_ri = 1'b0;
    logic [AW-1:0] pool [6];

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] read_model(input logic en, wr, oe, hi, lo,
                                                 input logic [DW-1:0] word);
        logic [DW-1:0] v;
        v = '0;
        if (en && !wr && oe) begin
            if (lo) v[7:0]  = word[7:0];
            if (hi) v[15:8] = word[15:8];
        end
        return v;
    endfunction

    function automatic logic [DW-1:0] merge(input logic hi, lo,
                                            input logic [DW-1:0] old, nw);
        logic [DW-1:0] v;
        v = old;
        if (lo) v[7:0]  = nw[7:0];
        if (hi) v[15:8] = nw[15:8];
        return v;
    endfunction

    task automatic set_l(input logic en, wr, oe, hi, lo, input logic [AW-1:0] a,
                         input logic [DW-1:0] d);
        l_en = en; l_wr = wr; l_oe = oe; l_hi_en = hi; l_lo_en = lo; l_addr = a; l_wdata = d;
    endtask

    task automatic set_r(input logic en, wr, oe, hi, lo, input logic [AW-1:0] a,
                         input logic [DW-1:0] d);
        r_en = en; r_wr = wr; r_oe = oe; r_hi_en = hi; r_lo_en = lo; r_addr = a; r_wdata = d;
    endtask

    // One cycle: inputs already set at a falling edge
    task automatic step(input string tag);
        logic lb, rb, lgo, rgo, sr, cr, sl, cl;
        logic [DW-1:0] el, er;
        #1;
        if (is_master) begin
            lb = 1'b0;
            rb = l_en && r_en && (l_addr == r_addr);
        end else begin
            lb = l_busy_in;
            rb = r_busy_in;
        end
        chk({tag, " R5 R7 left busy"}, l_busy, lb);
        chk({tag, " R5 R7 right busy"}, r_busy, rb);
        el = read_model(l_en, l_wr, l_oe, l_hi_en, l_lo_en, mdl[l_addr]);
        er = read_model(r_en, r_wr, r_oe, r_hi_en, r_lo_en, mdl[r_addr]);
        lgo = l_en && l_wr && !lb;
        rgo = r_en && r_wr && !rb;
        sr = lgo && (l_hi_en || l_lo_en) && (l_addr == AW'(TOP));
        cr = r_en && !r_wr && (r_addr == AW'(TOP));
        sl = rgo && (r_hi_en || r_lo_en) && (r_addr == AW'(TOP - 1));
        cl = l_en && !l_wr && (l_addr == AW'(TOP - 1));
        if (rgo) mdl[r_addr] = merge(r_hi_en, r_lo_en, mdl[r_addr], r_wdata);
        if (lgo) mdl[l_addr] = merge(l_hi_en, l_lo_en, mdl[l_addr], l_wdata);
        if (sr) exp_ri = 1'b1; else if (cr) exp_ri = 1'b0;
        if (sl) exp_li = 1'b1; else if (cl) exp_li = 1'b0;
        @(negedge clk);
        chk({tag, " R1 R3 R4 left rdata"}, l_rdata, el);
        chk({tag, " R1 R3 R4 right rdata"}, r_rdata, er);
        chk({tag, " R8 R9 R10 left int"}, l_int, exp_li);
        chk({tag, " R8 R9 R10 right int"}, r_int, exp_ri);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1357));
        pool[0] = 0; pool[1] = 1; pool[2] = 2; pool[3] = 3;
        pool[4] = AW'(TOP - 1); pool[5] = AW'(TOP);
        rst_n = 1'b0; is_master = 1'b1; l_busy_in = 1'b0; r_busy_in = 1'b0;
        set_l(0, 0, 0, 0, 0, '0, '0);
        set_r(0, 0, 0, 0, 0, '0, '0);
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10 reset left rdata", l_rdata, 0);
        chk("R10 reset right rdata", r_rdata, 0);
        chk("R10 reset left int", l_int, 0);
        chk("R10 reset right int", r_int, 0);
        rst_n = 1'b1;

        // R1 fill the pool words from the left side
        for (int i = 0; i < 6; i++) begin
            set_l(1, 1, 1, 1, 1, pool[i], DW'(16'h1100 * (i + 1) + i));
            step("R1 fill");
        end
        // R1 both sides read different words in one cycle
        set_l(1, 0, 1, 1, 1, pool[0], '0);
        set_r(1, 0, 1, 1, 1, pool[1], '0);
        step("R1 dual read");
        // R1 read-first: right reads word 3 while left writes it (slave, no busy)
        is_master = 1'b0;
        set_l(1, 1, 1, 1, 1, pool[3], 16'h5A5A);
        set_r(1, 0, 1, 1, 1, pool[3], '0);
        step("R1 read first");
        is_master = 1'b1;
        // R3 upper lane only write, then full read
        set_l(1, 1, 1, 1, 0, pool[1], 16'hABCD);
        set_r(0, 0, 0, 0, 0, '0, '0);
        step("R3 hi lane write");
        set_l(1, 0, 1, 1, 1, pool[1], '0);
        step("R3 readback");
        // R4 output enable low and single lane reads
        set_l(1, 0, 0, 1, 1, pool[1], '0);
        set_r(1, 0, 1, 0, 1, pool[0], '0);
        step("R4 oe low / lo lane");
        // R6 master collision on word 2
        set_l(1, 1, 1, 1, 1, pool[2], 16'h1111);
        set_r(1, 1, 1, 1, 1, pool[2], 16'h2222);
        step("R6 collision write");
        set_l(0, 0, 0, 0, 0, '0, '0);
        set_r(1, 0, 1, 1, 1, pool[2], '0);
        step("R6 collision readback");
        // R7 slave mode: blocked right write, read still proceeds
        is_master = 1'b0; r_busy_in = 1'b1;
        set_r(1, 1, 1, 1, 1, pool[3], 16'hDEAD);
        step("R7 blocked write");
        set_r(1, 0, 1, 1, 1, pool[3], '0);
        step("R7 busy read");
        r_busy_in = 1'b0; is_master = 1'b1;
        // R2 disabled side with write select high touches nothing
        set_l(0, 1, 1, 1, 1, pool[0], 16'hFFFF);
        set_r(0, 0, 0, 0, 0, '0, '0);
        step("R2 disabled");
        set_l(1, 0, 1, 1, 1, pool[0], '0);
        step("R2 readback");
        // R8 right reads top word, clearing its flag
        set_l(0, 0, 0, 0, 0, '0, '0);
        set_r(1, 0, 1, 1, 1, pool[5], '0);
        step("R8 clear");
        // R9 right writes top-1, left reads it
        set_r(1, 1, 1, 0, 1, pool[4], 16'h0042);
        step("R9 set");
        set_r(0, 0, 0, 0, 0, '0, '0);
        set_l(1, 0, 1, 1, 1, pool[4], '0);
        step("R9 clear");
        // R10 set and clear of the right flag in one cycle (slave, no busy)
        is_master = 1'b0;
        set_l(1, 1, 1, 1, 1, pool[5], 16'h7777);
        set_r(1, 0, 1, 1, 1, pool[5], '0);
        step("R10 set wins");
        is_master = 1'b1;

        // Random traffic on the pool words in both strap modes
        for (int n = 0; n < 4000; n++) begin
            if (n % 500 == 0) is_master = ~is_master;
            l_busy_in = ($urandom % 4) == 0;
            r_busy_in = ($urandom % 4) == 0;
            set_l($urandom % 8 != 0, $urandom % 2, $urandom % 8 != 0, $urandom % 4 != 0,
                  $urandom % 4 != 0, pool[$urandom % 6], DW'($urandom));
            set_r($urandom % 8 != 0, $urandom % 2, $urandom % 8 != 0, $urandom % 4 != 0,
                  $urandom % 4 != 0, pool[$urandom % 6], DW'($urandom));
            step("random");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule